// File: doc/BRIEF.md
# Generic Command Packet Front End

This block sits between a software-visible register window and the byte link layer of a display serial link host. Software stages the payload of a long packet as 32-bit words in a write payload queue and then writes a packet header word into a command queue. The block takes each header from the queue and sends its three header bytes on a valid/ready byte stream. For a long packet it then sends exactly the number of payload bytes given by the word count, taken from the staged words in little-endian order.

Read requests set a busy flag once their header has gone out. While the flag is set, no further header is taken from the queue. Response bytes from the link are packed little-endian into words and placed in a read payload queue, which software drains through a read strobe. A six-bit status word gives the empty and full state of all three queues. Two sticky flags record a dropped write and a read from an empty response queue.

Top module: `gcmd_pkt_if`

## Requirements
- R1: After reset the status word is 6'b010101, and rd_busy, tx_valid, ovf_flag and unf_flag are all 0.
- R2: A header word sends three bytes in this order: {bits 7:6 virtual channel, bits 5:0 data type}, then bits 15:8, then bits 23:16. Bits 31:24 of the header word have no effect on any output.
- R3: A data type whose low nibble is 4'h9 (for example 6'h29 and 6'h39) is long. Every other type is short. A short packet is exactly the three header bytes and takes no word from the write payload queue.
- R4: A long packet with word count N (bits 23:8) sends its three header bytes and then exactly N payload bytes. Byte k comes from byte lane k mod 4 (lane 0 = bits 7:0) of staged word k/4. The packet takes ceil(N/4) words from the queue, and the unused lanes of its last word are dropped.
- R5: tx_last is 1 on the final byte of each packet and 0 on every other byte. For a long packet with N = 0, the final byte is the third header byte.
- R6: While tx_valid is 1 and tx_ready is 0, tx_valid, tx_byte and tx_last hold their values. Back-pressure does not change the byte sequence that is sent.
- R7: A read type (low nibble 4'h4, or type 6'h06) sets rd_busy when its last header byte is accepted. While rd_busy is 1, no further header is sent. rd_busy clears on the response byte that carries rsp_last.
- R8: Response bytes are packed little-endian, four to a word. A word is pushed after its fourth byte or after the byte marked rsp_last, with its unused upper lanes zero. Response bytes that arrive while rd_busy is 0 are ignored.
- R9: The status word is, from bit 0 up: command empty, command full, write payload empty, write payload full, read payload empty, read payload full.
- R10: A write to a full queue is dropped, and ovf_flag is set and stays set until reset.
- R11: A read strobe on an empty read payload queue returns 0 on pld_rdata, and unf_flag is set and stays set until reset.
- R12: pld_rdata shows the oldest word in the read payload queue, and pld_rd removes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hdr_wr | input | 1 | Push hdr_data into the command queue |
| hdr_data | input | 32 | Packet header word |
| pld_wr | input | 1 | Push pld_wdata into the write payload queue |
| pld_wdata | input | 32 | Payload word, little-endian bytes |
| pld_rd | input | 1 | Pop the read payload queue |
| pld_rdata | output | 32 | Oldest response word, or 0 when the queue is empty |
| fifo_status | output | 6 | Empty/full state of the three queues |
| ovf_flag | output | 1 | Sticky dropped-write flag |
| unf_flag | output | 1 | Sticky empty-read flag |
| rd_busy | output | 1 | Read in progress, waiting for the response |
| tx_valid | output | 1 | Output byte valid |
| tx_ready | input | 1 | Link accepts the output byte |
| tx_byte | output | 8 | Output byte |
| tx_last | output | 1 | Final byte of the packet |
| rsp_valid | input | 1 | Response byte valid |
| rsp_byte | input | 8 | Response byte |
| rsp_last | input | 1 | Final response byte |

## Verification
The assertions rely on three things from the inputs. Software writes all payload words of a long packet before its header. Response bytes arrive only after a read header has been sent. rsp_last marks the end of each response. The stimulus follows these rules in every section except the one where response bytes are sent while no read is pending, which tests that they are dropped.

The sweeps cover every data type, every word count from 0 to 13, and a full-depth payload of 256 bytes. Expected bytes are derived from the requirement formulas, using filler values in the lanes that must be dropped.

// File: rtl/gcmd_pkg.sv
package gcmd_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_HDR, ST_PLD} seq_state_e;

  function automatic logic dt_is_long(logic [5:0] dt);
    return dt[3:0] == 4'h9;
  endfunction

  function automatic logic dt_is_read(logic [5:0] dt);
    return (dt[3:0] == 4'h4) || (dt == 6'h06);
  endfunction

  function automatic logic [7:0] lane_get(logic [31:0] w, logic [1:0] l);
    return w[{l, 3'b000} +: 8];
  endfunction

  function automatic logic [31:0] lane_put(logic [31:0] w, logic [1:0] l, logic [7:0] b);
    logic [31:0] r;
    r = w;
    r[{l, 3'b000} +: 8] = b;
    return r;
  endfunction
endpackage

// File: rtl/gcmd_fifo.sv
module gcmd_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rp, wp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rp  <= '0;
      wp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
      if (do_push && !do_pop)      cnt <= cnt + 1'b1;
      else if (do_pop && !do_push) cnt <= cnt - 1'b1;
    end
  end

  // R10: occupancy never exceeds the depth
  p_cnt_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  // R10: a push into a full queue without a pop leaves it full
  p_full_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    full && push && !pop |=> full);
endmodule

// File: rtl/gcmd_tx_seq.sv
module gcmd_tx_seq
  import gcmd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_empty,
  input  logic [23:0] cmd_head,
  output logic        cmd_pop,
  input  logic        pld_empty,
  input  logic [31:0] pld_head,
  output logic        pld_pop,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [7:0]  tx_byte,
  output logic        tx_last,
  input  logic        rsp_done,
  output logic        rd_busy
);
  seq_state_e  st;
  logic [23:0] hdr;
  logic [1:0]  bidx, lane;
  logic [15:0] rem;
  logic        busy, fire, has_pld, hdr_done;
  logic [15:0] wc;
  logic [5:0]  dt;

  assign wc       = hdr[23:8];
  assign dt       = hdr[5:0];
  assign has_pld  = dt_is_long(dt) && (wc != 16'd0);
  assign fire     = tx_valid && tx_ready;
  assign hdr_done = (st == ST_HDR) && fire && (bidx == 2'd2);
  assign rd_busy  = busy;

  always_comb begin
    tx_valid = 1'b0;
    tx_byte  = 8'h00;
    tx_last  = 1'b0;
    cmd_pop  = 1'b0;
    pld_pop  = 1'b0;
    case (st)
      ST_IDLE: cmd_pop = !cmd_empty && !busy;
      ST_HDR: begin
        tx_valid = 1'b1;
        tx_byte  = lane_get({8'h00, hdr}, bidx);
        tx_last  = (bidx == 2'd2) && !has_pld;
      end
      ST_PLD: begin
        tx_valid = !pld_empty;
        tx_byte  = lane_get(pld_head, lane);
        tx_last  = (rem == 16'd1);
        pld_pop  = tx_valid && tx_ready && ((lane == 2'd3) || (rem == 16'd1));
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      hdr  <= '0;
      bidx <= '0;
      lane <= '0;
      rem  <= '0;
    end else begin
      case (st)
        ST_IDLE: if (cmd_pop) begin
          hdr  <= cmd_head;
          bidx <= 2'd0;
          st   <= ST_HDR;
        end
        ST_HDR: if (fire) begin
          if (bidx == 2'd2) begin
            if (has_pld) begin
              st   <= ST_PLD;
              rem  <= wc;
              lane <= 2'd0;
            end else begin
              st <= ST_IDLE;
            end
          end else begin
            bidx <= bidx + 1'b1;
          end
        end
        ST_PLD: if (fire) begin
          rem  <= rem - 1'b1;
          lane <= lane + 1'b1;
          if (rem == 16'd1) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                        busy <= 1'b0;
    else if (rsp_done)                 busy <= 1'b0;
    else if (hdr_done && dt_is_read(dt)) busy <= 1'b1;
  end

  // R6: a stalled byte holds until it is accepted
  p_tx_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_byte) && $stable(tx_last));
  // R7: nothing is dequeued while a read waits for its response
  p_busy_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cmd_pop);
  // R7: busy persists until the response ends
  p_busy_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !rsp_done |=> busy);
endmodule

// File: rtl/gcmd_rx_pack.sv
module gcmd_rx_pack
  import gcmd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        accept,
  input  logic        rsp_valid,
  input  logic [7:0]  rsp_byte,
  input  logic        rsp_last,
  output logic        push,
  output logic [31:0] word,
  output logic        done
);
  logic [31:0] acc;
  logic [1:0]  nb;
  logic        take;

  assign take = rsp_valid && accept;
  assign word = lane_put(acc, nb, rsp_byte);
  assign push = take && ((nb == 2'd3) || rsp_last);
  assign done = take && rsp_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc <= '0;
      nb  <= '0;
    end else if (take) begin
      if (push) begin
        acc <= '0;
        nb  <= '0;
      end else begin
        acc <= word;
        nb  <= nb + 1'b1;
      end
    end
  end

  // R8: no response word is produced while no read is pending
  p_ignore_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |-> !push && !done);
endmodule

// File: rtl/gcmd_pkt_if.sv
module gcmd_pkt_if #(
  parameter int CMD_DEPTH = 4,
  parameter int PLD_DEPTH = 64,
  parameter int RSP_DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hdr_wr,
  input  logic [31:0] hdr_data,
  input  logic        pld_wr,
  input  logic [31:0] pld_wdata,
  input  logic        pld_rd,
  output logic [31:0] pld_rdata,
  output logic [5:0]  fifo_status,
  output logic        ovf_flag,
  output logic        unf_flag,
  output logic        rd_busy,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [7:0]  tx_byte,
  output logic        tx_last,
  input  logic        rsp_valid,
  input  logic [7:0]  rsp_byte,
  input  logic        rsp_last
);
  logic        cf_empty, cf_full, wf_empty, wf_full, rf_empty, rf_full;
  logic [23:0] cf_head;
  logic [31:0] wf_head, rf_head, rsp_word;
  logic        cmd_pop, pld_pop, rsp_push, rsp_done;
  logic        ovf_evt, unf_evt;
  logic [7:0]  unused_hdr_hi;

  assign unused_hdr_hi = hdr_data[31:24];

  gcmd_fifo #(.W(24), .DEPTH(CMD_DEPTH)) u_cmd (
    .clk, .rst_n, .push(hdr_wr), .wdata(hdr_data[23:0]), .pop(cmd_pop),
    .rdata(cf_head), .empty(cf_empty), .full(cf_full));

  gcmd_fifo #(.W(32), .DEPTH(PLD_DEPTH)) u_wpld (
    .clk, .rst_n, .push(pld_wr), .wdata(pld_wdata), .pop(pld_pop),
    .rdata(wf_head), .empty(wf_empty), .full(wf_full));

  gcmd_fifo #(.W(32), .DEPTH(RSP_DEPTH)) u_rpld (
    .clk, .rst_n, .push(rsp_push), .wdata(rsp_word), .pop(pld_rd),
    .rdata(rf_head), .empty(rf_empty), .full(rf_full));

  gcmd_tx_seq u_seq (
    .clk, .rst_n, .cmd_empty(cf_empty), .cmd_head(cf_head), .cmd_pop,
    .pld_empty(wf_empty), .pld_head(wf_head), .pld_pop,
    .tx_valid, .tx_ready, .tx_byte, .tx_last, .rsp_done, .rd_busy);

  gcmd_rx_pack u_pack (
    .clk, .rst_n, .accept(rd_busy), .rsp_valid, .rsp_byte, .rsp_last,
    .push(rsp_push), .word(rsp_word), .done(rsp_done));

  assign fifo_status = {rf_full, rf_empty, wf_full, wf_empty, cf_full, cf_empty};
  assign pld_rdata   = rf_empty ? 32'h0 : rf_head;
  assign ovf_evt     = (hdr_wr && cf_full) || (pld_wr && wf_full) || (rsp_push && rf_full);
  assign unf_evt     = pld_rd && rf_empty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf_flag <= 1'b0;
      unf_flag <= 1'b0;
    end else begin
      if (ovf_evt) ovf_flag <= 1'b1;
      if (unf_evt) unf_flag <= 1'b1;
    end
  end

  // R10: overflow flag is sticky
  p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag |=> ovf_flag);
  // R11: underflow flag is sticky
  p_unf_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    unf_flag |=> unf_flag);
  // R4: payload words are consumed only while a packet is being sent
  p_pop_in_pkt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pld_pop |-> tx_valid && tx_ready);
endmodule

// File: tb/sim_gcmd_pkt_if.sv
module sim_gcmd_pkt_if;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hdr_wr = 1'b0, pld_wr = 1'b0, pld_rd = 1'b0;
  logic [31:0] hdr_data = '0, pld_wdata = '0;
  logic [31:0] pld_rdata;
  logic [5:0]  fifo_status;
  logic        ovf_flag, unf_flag, rd_busy, tx_valid, tx_last;
  logic        tx_ready = 1'b1;
  logic [7:0]  tx_byte;
  logic        rsp_valid = 1'b0, rsp_last = 1'b0;
  logic [7:0]  rsp_byte = '0;

  int nchk = 0, nfail = 0, capn = 0;
  logic [7:0] cap [0:4095];
  logic       capl [0:4095];

  always #4 clk = ~clk;

  gcmd_pkt_if u0 (.*);

  always @(posedge clk) begin
    if (rst_n && tx_valid && tx_ready) begin
      cap[capn]  <= tx_byte;
      capl[capn] <= tx_last;
      capn       <= capn + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic put_hdr(input logic [31:0] d);
    @(negedge clk); hdr_wr = 1'b1; hdr_data = d;
    @(negedge clk); hdr_wr = 1'b0;
  endtask

  task automatic put_pld(input logic [31:0] d);
    @(negedge clk); pld_wr = 1'b1; pld_wdata = d;
    @(negedge clk); pld_wr = 1'b0;
  endtask

  task automatic get_rsp(output logic [31:0] d);
    @(negedge clk); d = pld_rdata; pld_rd = 1'b1;
    @(negedge clk); pld_rd = 1'b0;
  endtask

  task automatic send_rsp(input logic [7:0] b, input bit last);
    @(negedge clk); rsp_valid = 1'b1; rsp_byte = b; rsp_last = last;
    @(negedge clk); rsp_valid = 1'b0; rsp_last = 1'b0;
  endtask

  function automatic logic [7:0] pb(input int p, input int k);
    return 8'((p * 7 + k * 13 + 1) & 255);
  endfunction

  // Stage N bytes of pattern p; unused lanes of the last word carry filler 8'hEE
  task automatic stage(input int p, input int n);
    for (int j = 0; j < (n + 3) / 4; j++) begin
      logic [31:0] w;
      for (int l = 0; l < 4; l++)
        w[l*8 +: 8] = (4 * j + l < n) ? pb(p, 4 * j + l) : 8'hEE;
      put_pld(w);
    end
  endtask

  task automatic check_pkt(input int base, input logic [5:0] dt, input logic [1:0] vc,
                           input logic [7:0] p0, input logic [7:0] p1, input int n, input int p,
                           input string tag);
    int len;
    len = 3 + n;
    chk(capn - base == len, {tag, " length R3 R4"}, capn - base, len);
    chk(cap[base] == {vc, dt}, "R2 first header byte", cap[base], {vc, dt});
    chk(cap[base+1] == p0 && cap[base+2] == p1, "R2 header bytes 2-3",
        {cap[base+1], cap[base+2]}, {p0, p1});
    for (int k = 0; k < n; k++)
      chk(cap[base+3+k] == pb(p, k), "R4 payload byte", cap[base+3+k], pb(p, k));
    for (int k = 0; k < len; k++)
      chk(capl[base+k] == (k == len - 1), "R5 last marker", capl[base+k], k == len - 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int base;
    do_reset();
    // R1, R9: reset state
    chk(fifo_status == 6'b010101, "R1 R9 reset status", fifo_status, 6'b010101);
    chk({rd_busy, tx_valid, ovf_flag, unf_flag} == 4'b0, "R1 reset flags",
        {rd_busy, tx_valid, ovf_flag, unf_flag}, 0);

    // R4 R5: long packets, word counts 0..13
    for (int n = 0; n < 14; n++) begin
      logic [5:0] dt;
      dt = n[0] ? 6'h39 : 6'h29;
      base = capn;
      stage(n, n);
      put_hdr({8'hA5, 8'h00, 8'(n), 2'(n), dt});
      repeat (3 * n + 20) @(negedge clk);
      check_pkt(base, dt, 2'(n), 8'(n), 8'h00, n, n, "long");
      chk(fifo_status[2] == 1'b1, "R4 payload words consumed", fifo_status, 6'b000100);
    end

    // R2 R3: every non-read data type
    for (int t = 0; t < 64; t++) begin
      logic [5:0] dt;
      dt = 6'(t);
      if (dt[3:0] == 4'h4 || dt == 6'h06) continue;
      base = capn;
      if (dt[3:0] == 4'h9) begin
        stage(100 + t, 2);
        put_hdr({8'h5C, 8'h00, 8'h02, 2'(t >> 2), dt});
        repeat (20) @(negedge clk);
        check_pkt(base, dt, 2'(t >> 2), 8'h02, 8'h00, 2, 100 + t, "long type");
      end else begin
        put_hdr({8'hFF, 8'(t + 3), 8'(t ^ 8'h5A), 2'(t >> 2), dt});
        repeat (12) @(negedge clk);
        check_pkt(base, dt, 2'(t >> 2), 8'(t ^ 8'h5A), 8'(t + 3), 0, 0, "short type");
      end
      chk(fifo_status[2] == 1'b1, "R3 payload queue empty", fifo_status, 6'b000100);
    end

    // R6: back-pressure on a 10-byte long packet
    base = capn;
    stage(77, 10);
    put_hdr({8'h00, 8'h00, 8'd10, 2'd3, 6'h29});
    for (int c = 0; c < 60; c++) begin
      @(negedge clk); tx_ready = (c % 3) != 0;
    end
    @(negedge clk); tx_ready = 1'b1;
    repeat (10) @(negedge clk);
    check_pkt(base, 6'h29, 2'd3, 8'd10, 8'h00, 10, 77, "R6 backpressure");

    // R7 R8 R11 R12: read request and response
    do_reset();
    base = capn;
    put_hdr({8'h00, 8'h34, 8'h12, 2'd1, 6'h14});
    repeat (10) @(negedge clk);
    chk(rd_busy == 1'b1, "R7 busy after read header", rd_busy, 1);
    chk(capn - base == 3, "R7 read header sent", capn - base, 3);
    base = capn;
    put_hdr({8'h00, 8'h00, 8'h00, 2'd0, 6'h05});
    repeat (10) @(negedge clk);
    chk(capn == base, "R7 header held while busy", capn - base, 0);
    chk(fifo_status[0] == 1'b0, "R7 header still queued", fifo_status, 6'b0);
    for (int i = 0; i < 6; i++) send_rsp(8'hC0 + 8'(i), i == 5);
    chk(rd_busy == 1'b0, "R7 busy cleared by last byte", rd_busy, 0);
    repeat (10) @(negedge clk);
    chk(capn - base == 3, "R7 next header sent after response", capn - base, 3);
    chk(fifo_status[4] == 1'b0, "R9 read queue not empty", fifo_status, 6'b0);
    get_rsp(d);
    chk(d == 32'hC3C2C1C0, "R8 R12 first response word", d, 32'hC3C2C1C0);
    get_rsp(d);
    chk(d == 32'h0000C5C4, "R8 R12 padded response word", d, 32'h0000C5C4);
    chk(fifo_status[4] == 1'b1 && unf_flag == 1'b0, "R12 read queue drained",
        {fifo_status, unf_flag}, 7'b0100000);
    get_rsp(d);
    chk(d == 32'h0, "R11 empty read returns zero", d, 0);
    chk(unf_flag == 1'b1, "R11 underflow flag", unf_flag, 1);
    send_rsp(8'h11, 1'b0);
    send_rsp(8'h22, 1'b1);
    repeat (2) @(negedge clk);
    chk(fifo_status[4] == 1'b1, "R8 idle response ignored", fifo_status, 6'b010000);
    chk(unf_flag == 1'b1, "R11 underflow sticky", unf_flag, 1);

    // R10: command queue overflow
    do_reset();
    tx_ready = 1'b0;
    base = capn;
    for (int i = 0; i < 6; i++) put_hdr({8'h00, 8'h00, 8'(i), 2'd0, 6'h03});
    chk(fifo_status[1] == 1'b1, "R9 R10 command queue full", fifo_status, 6'b000010);
    chk(ovf_flag == 1'b1, "R10 overflow flag", ovf_flag, 1);
    @(negedge clk); tx_ready = 1'b1;
    repeat (40) @(negedge clk);
    chk(capn - base == 15, "R10 dropped header not sent", capn - base, 15);
    chk(cap[base+13] == 8'd4, "R10 last kept header", cap[base+13], 4);

    // R10 R4: payload queue overflow and a full-depth packet
    base = capn;
    for (int j = 0; j < 65; j++) put_pld({4{8'(j)}});
    chk(fifo_status[3] == 1'b1, "R9 R10 payload queue full", fifo_status, 6'b001000);
    put_hdr({8'h00, 8'h01, 8'h00, 2'd2, 6'h29});
    repeat (300) @(negedge clk);
    chk(capn - base == 259, "R4 full-depth length", capn - base, 259);
    chk(cap[base+258] == 8'd63 && capl[base+258], "R4 R10 final byte from last kept word",
        cap[base+258], 63);
    chk(fifo_status[2] == 1'b1, "R10 dropped word never stored", fifo_status, 6'b000100);
    chk(ovf_flag == 1'b1, "R10 overflow sticky", ovf_flag, 1);

    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule